// File: doc/BRIEF.md
# Serial Trigger-Line Command Decoder

This block listens to a single serial trigger line and recovers short 4-bit command words sent on it with Manchester coding. Nothing on the line acts through its static level. A rising edge seen while the decoder is idle opens a frame. The first bit time of the frame is a start mark that must stay high for both of its half-bits. Four data bits follow, most significant bit first. Each data bit is coded by the direction of its mid-bit transition.

The line passes through a two-flop synchronizer and is oversampled by the system clock. Each half-bit is sampled once, near its centre, using a down-counter reloaded from the half-bit period parameter. A complete frame produces a one-cycle command strobe together with the code. The decoded command then drives registered readout mode flags: trigger enable, standard run, raw-data dump, and a one-cycle start pulse for the gated sequence. A frame with a broken start mark or a Manchester code violation is dropped and flagged by a one-cycle error strobe.

Top module: `trig_cmd_decoder`

## Requirements
- R1: After reset, trig_en, run_active, dump_mode, gate_start, cmd_valid, cmd_unknown and cmd_err are all 0.
- R2: A well-formed frame whose rising edge reaches the input just before clock edge P0 makes cmd_valid high for exactly one cycle. That cycle follows edge P(9*HALF_CYC + HALF_CYC/2 + 2). cmd_code carries the received word in that cycle.
- R3: A frame is a start bit with both half-bits high, followed by 4 data bits sent MSB first. A data 0 is sent as high then low, and a data 1 as low then high.
- R4: If both half-bits of a data symbol sample the same level, the frame is dropped. cmd_err pulses for one cycle after the second half of that symbol is sampled, cmd_valid does not pulse, and the mode flags keep their values.
- R5: If the second start half-bit samples low, cmd_err pulses for one cycle after that sample and no command is produced.
- R6: Holding the line at a static level produces at most one error for the rising edge that begins the hold. A line that stays low or stays high afterwards produces no further strobe.
- R7: Code 0x1 sets trig_en and code 0x2 clears it. Flags change in the cycle after cmd_valid and at no other time.
- R8: Code 0x3 sets run_active and clears dump_mode. Code 0x4 clears both run_active and dump_mode.
- R9: Code 0x5 sets dump_mode and clears run_active, so the two are never high together.
- R10: Code 0x6 pulses gate_start for one cycle, in the cycle after cmd_valid, only while run_active is 1. Outside run mode the code is ignored.
- R11: Codes 0x0 and 0x7 to 0xF pulse cmd_valid with cmd_unknown high and leave all mode flags unchanged.
- R12: cmd_valid and cmd_err are never high together, and cmd_unknown is high only together with cmd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_line_i | input | 1 | Asynchronous serial trigger line |
| cmd_valid_o | output | 1 | One-cycle strobe for a complete frame |
| cmd_code_o | output | 4 | Last received command word |
| cmd_unknown_o | output | 1 | The strobed code is unassigned |
| cmd_err_o | output | 1 | One-cycle strobe for a dropped frame |
| trig_en_o | output | 1 | Trigger readout enabled |
| run_active_o | output | 1 | Standard operation active |
| dump_mode_o | output | 1 | Raw-data transfer mode selected |
| gate_start_o | output | 1 | One-cycle start of the gated sequence |

## Verification
Count the clock edges from the one where the opening rising edge enters the synchronizer. Half-bit k is sampled after edge HALF_CYC/2 + 1 + k*HALF_CYC, and a strobe caused by that sample is visible one edge later. A valid frame therefore strobes after edge 9*HALF_CYC + HALF_CYC/2 + 2. A violation in data symbol i strobes after edge (2i+3)*HALF_CYC + HALF_CYC/2 + 2. The mode flags and the gated-start pulse follow one further edge later. The bench resets a cycle counter when it applies a frame and logs each strobe with its counter value at the falling edge. It compares that value with the figures above, and reads the flags only after the frame has ended and the line has been idle for several half-bits.

// File: rtl/trig_cmd_pkg.sv
package trig_cmd_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        CMD_TRIG_ON  = 4'h1,
        CMD_TRIG_OFF = 4'h2,
        CMD_RUN      = 4'h3,
        CMD_STOP     = 4'h4,
        CMD_DUMP     = 4'h5,
        CMD_VETO     = 4'h6
    } cmd_e;

    typedef enum logic {
        RX_IDLE,
        RX_BUSY
    } rx_state_e;

    function automatic logic cmd_known(input logic [CMD_W-1:0] code);
        return (code >= 4'h1) && (code <= 4'h6);
    endfunction

endpackage

// File: rtl/trig_line_sync.sv
module trig_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/trig_frame_rx.sv
module trig_frame_rx
    import trig_cmd_pkg::*;
#(
    parameter int HALF_CYC = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             line_i,
    output logic             valid_o,
    output logic [CMD_W-1:0] code_o,
    output logic             unknown_o,
    output logic             err_o
);
    localparam int CNT_W     = $clog2(HALF_CYC) + 1;
    localparam int N_HALVES  = 2 * CMD_W + 2;
    localparam int HIDX_W    = $clog2(N_HALVES);
    localparam logic [HIDX_W-1:0] LAST_HALF = HIDX_W'(N_HALVES - 1);
    localparam logic [CNT_W-1:0]  FIRST_WAIT = CNT_W'(HALF_CYC / 2 - 1);
    localparam logic [CNT_W-1:0]  HALF_WAIT  = CNT_W'(HALF_CYC - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [HIDX_W-1:0] hidx;
        logic              first;
        logic              prev;
        logic [CMD_W-1:0]  word;
        logic              valid;
        logic [CMD_W-1:0]  code;
        logic              unknown;
        logic              err;
    } rx_t;

    rx_t d, q;
    logic [CMD_W-1:0] next_word;

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        d.unknown = 1'b0;
        d.err     = 1'b0;
        d.prev    = line_i;
        next_word = {q.word[CMD_W-2:0], line_i};
        case (q.state)
            RX_IDLE: begin
                if (line_i && !q.prev) begin
                    d.state = RX_BUSY;
                    d.cnt   = FIRST_WAIT;
                    d.hidx  = '0;
                    d.word  = '0;
                end
            end
            default: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.cnt  = HALF_WAIT;
                    d.hidx = q.hidx + 1'b1;
                    if (!q.hidx[0]) begin
                        d.first = line_i;
                    end else if (q.hidx == HIDX_W'(1)) begin
                        if (!(q.first && line_i)) begin
                            d.err   = 1'b1;
                            d.state = RX_IDLE;
                        end
                    end else if (q.first == line_i) begin
                        d.err   = 1'b1;
                        d.state = RX_IDLE;
                    end else begin
                        d.word = next_word;
                        if (q.hidx == LAST_HALF) begin
                            d.valid   = 1'b1;
                            d.code    = next_word;
                            d.unknown = !cmd_known(next_word);
                            d.state   = RX_IDLE;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{state: RX_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign valid_o   = q.valid;
    assign code_o    = q.code;
    assign unknown_o = q.unknown;
    assign err_o     = q.err;

    AST_VALID_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_o && err_o)); // R12
    AST_UNKNOWN_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        unknown_o |-> valid_o); // R12
    AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o); // R2
    AST_ERR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> !err_o); // R4
    AST_CODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_o |=> (valid_o || $stable(code_o))); // R2
endmodule

// File: rtl/trig_mode_ctrl.sv
module trig_mode_ctrl
    import trig_cmd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmd_valid_i,
    input  logic [CMD_W-1:0] cmd_code_i,
    output logic             trig_en_o,
    output logic             run_active_o,
    output logic             dump_mode_o,
    output logic             gate_start_o
);
    typedef struct packed {
        logic trig_en;
        logic run;
        logic dump;
        logic gate;
    } mode_t;

    mode_t d, q;

    always_comb begin
        d      = q;
        d.gate = 1'b0;
        if (cmd_valid_i) begin
            case (cmd_code_i)
                CMD_TRIG_ON:  d.trig_en = 1'b1;
                CMD_TRIG_OFF: d.trig_en = 1'b0;
                CMD_RUN:      begin d.run = 1'b1; d.dump = 1'b0; end
                CMD_STOP:     begin d.run = 1'b0; d.dump = 1'b0; end
                CMD_DUMP:     begin d.run = 1'b0; d.dump = 1'b1; end
                CMD_VETO:     d.gate = q.run;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign trig_en_o    = q.trig_en;
    assign run_active_o = q.run;
    assign dump_mode_o  = q.dump;
    assign gate_start_o = q.gate;

    AST_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cmd_valid_i |=> $stable({trig_en_o, run_active_o, dump_mode_o})); // R7
    AST_UNKNOWN_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && !cmd_known(cmd_code_i)) |=>
            ($stable({trig_en_o, run_active_o, dump_mode_o}) && !gate_start_o)); // R11
    AST_GATE_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gate_start_o |-> run_active_o); // R10
    AST_RUN_DUMP_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(run_active_o && dump_mode_o)); // R9
endmodule

// File: rtl/trig_cmd_decoder.sv
module trig_cmd_decoder
    import trig_cmd_pkg::*;
#(
    parameter int HALF_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_line_i,
    output logic             cmd_valid_o,
    output logic [CMD_W-1:0] cmd_code_o,
    output logic             cmd_unknown_o,
    output logic             cmd_err_o,
    output logic             trig_en_o,
    output logic             run_active_o,
    output logic             dump_mode_o,
    output logic             gate_start_o
);
    logic line_s;

    trig_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (trig_line_i),
        .sync_o  (line_s)
    );

    trig_frame_rx #(.HALF_CYC(HALF_CYC)) rx_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .line_i    (line_s),
        .valid_o   (cmd_valid_o),
        .code_o    (cmd_code_o),
        .unknown_o (cmd_unknown_o),
        .err_o     (cmd_err_o)
    );

    trig_mode_ctrl mode_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cmd_valid_i  (cmd_valid_o),
        .cmd_code_i   (cmd_code_o),
        .trig_en_o    (trig_en_o),
        .run_active_o (run_active_o),
        .dump_mode_o  (dump_mode_o),
        .gate_start_o (gate_start_o)
    );
endmodule

// File: tb/trig_cmd_decoder_tb.sv
module trig_cmd_decoder_tb_top;
    localparam int H     = 8;
    localparam int LAT_V = 9 * H + H / 2 + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line = 1'b0;
    logic cmd_valid, cmd_unknown, cmd_err;
    logic [3:0] cmd_code;
    logic trig_en, run_active, dump_mode, gate_start;

    always #2 clk = ~clk;

    trig_cmd_decoder #(.HALF_CYC(H)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .trig_line_i   (line),
        .cmd_valid_o   (cmd_valid),
        .cmd_code_o    (cmd_code),
        .cmd_unknown_o (cmd_unknown),
        .cmd_err_o     (cmd_err),
        .trig_en_o     (trig_en),
        .run_active_o  (run_active),
        .dump_mode_o   (dump_mode),
        .gate_start_o  (gate_start)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    int n_valid = 0, n_err = 0, n_gate = 0, n_overlap = 0;
    int v_cyc = 0, e_cyc = 0, v_code = 0, v_unk = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cmd_valid) begin
            n_valid++; v_cyc = cyc; v_code = int'(cmd_code); v_unk = int'(cmd_unknown);
        end
        if (cmd_err) begin n_err++; e_cyc = cyc; end
        if (gate_start) n_gate++;
        if (cmd_valid && cmd_err) n_overlap++;
        if (cmd_unknown && !cmd_valid) n_overlap++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        cyc = 0; n_valid = 0; n_err = 0; n_gate = 0;
    endtask

    task automatic drive_seq(input logic [9:0] hv, input int n);
        @(negedge clk);
        clear_log();
        for (int k = 0; k < n; k++) begin
            line = hv[9-k];
            repeat (H) @(negedge clk);
        end
        line = 1'b0;
        repeat (4 * H) @(negedge clk);
    endtask

    function automatic logic [9:0] frame_of(input logic [3:0] c);
        logic [9:0] v;
        v[9:8] = 2'b11;
        for (int i = 0; i < 4; i++) begin
            v[7-2*i] = !c[3-i];
            v[6-2*i] = c[3-i];
        end
        return v;
    endfunction

    task automatic send_cmd(input logic [3:0] c, input string req);
        drive_seq(frame_of(c), 10);
        chk(n_valid == 1, req, n_valid, 1);
        chk(v_code == int'(c), req, v_code, int'(c));
        chk(v_cyc == LAT_V, "R2", v_cyc, LAT_V);
        chk(n_err == 0, "R12", n_err, 0);
    endtask

    task automatic t_reset();
        chk({trig_en, run_active, dump_mode, gate_start} == 4'b0, "R1",
            int'({trig_en, run_active, dump_mode, gate_start}), 0);
        chk({cmd_valid, cmd_unknown, cmd_err} == 3'b0, "R1",
            int'({cmd_valid, cmd_unknown, cmd_err}), 0);
    endtask

    task automatic t_trigger();
        send_cmd(4'h1, "R7");
        chk(trig_en == 1'b1, "R7", int'(trig_en), 1);
        chk(v_unk == 0, "R11", v_unk, 0);
        send_cmd(4'h2, "R7");
        chk(trig_en == 1'b0, "R7", int'(trig_en), 0);
        send_cmd(4'h1, "R7");
        chk(trig_en == 1'b1, "R7", int'(trig_en), 1);
    endtask

    task automatic t_run_veto_dump();
        send_cmd(4'h6, "R10");
        chk(n_gate == 0, "R10", n_gate, 0);
        send_cmd(4'h3, "R8");
        chk(run_active == 1'b1 && dump_mode == 1'b0, "R8", int'({run_active, dump_mode}), 2);
        send_cmd(4'h6, "R10");
        chk(n_gate == 1, "R10", n_gate, 1);
        chk(run_active == 1'b1, "R10", int'(run_active), 1);
        send_cmd(4'h5, "R9");
        chk(run_active == 1'b0 && dump_mode == 1'b1, "R9", int'({run_active, dump_mode}), 1);
        send_cmd(4'h6, "R10");
        chk(n_gate == 0, "R10", n_gate, 0);
        send_cmd(4'h3, "R8");
        chk(dump_mode == 1'b0, "R8", int'(dump_mode), 0);
        send_cmd(4'h4, "R8");
        chk(run_active == 1'b0 && dump_mode == 1'b0, "R8", int'({run_active, dump_mode}), 0);
    endtask

    task automatic t_unknown();
        logic [3:0] codes [3] = '{4'hA, 4'hF, 4'h0};
        for (int i = 0; i < 3; i++) begin
            send_cmd(codes[i], "R3");
            chk(v_unk == 1, "R11", v_unk, 1);
            chk(trig_en == 1'b1 && !run_active && !dump_mode, "R11",
                int'({trig_en, run_active, dump_mode}), 4);
            chk(n_gate == 0, "R11", n_gate, 0);
        end
    endtask

    task automatic t_data_violation();
        drive_seq(10'b11_01_00_00_00, 10);
        chk(n_err == 1, "R4", n_err, 1);
        chk(e_cyc == 5 * H + H / 2 + 3, "R4", e_cyc, 5 * H + H / 2 + 3);
        chk(n_valid == 0, "R4", n_valid, 0);
        chk(trig_en == 1'b1 && !run_active && !dump_mode, "R4",
            int'({trig_en, run_active, dump_mode}), 4);
        drive_seq(10'b11_11_00_00_00, 10);
        chk(n_err == 1 && n_valid == 0, "R4", n_err, 1);
        chk(e_cyc == 3 * H + H / 2 + 3, "R4", e_cyc, 3 * H + H / 2 + 3);
    endtask

    task automatic t_start_violation();
        drive_seq(10'b10_00_00_00_00, 2);
        chk(n_err == 1, "R5", n_err, 1);
        chk(e_cyc == H + H / 2 + 3, "R5", e_cyc, H + H / 2 + 3);
        chk(n_valid == 0, "R5", n_valid, 0);
    endtask

    task automatic t_static();
        @(negedge clk);
        clear_log();
        line = 1'b1;
        repeat (30 * H) @(negedge clk);
        chk(n_err == 1, "R6", n_err, 1);
        chk(n_valid == 0, "R6", n_valid, 0);
        line = 1'b0;
        clear_log();
        repeat (20 * H) @(negedge clk);
        chk(n_err == 0 && n_valid == 0, "R6", n_err + n_valid, 0);
        send_cmd(4'h2, "R6");
        chk(trig_en == 1'b0, "R7", int'(trig_en), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_trigger();
        t_run_veto_dump();
        t_unknown();
        t_data_violation();
        t_start_violation();
        t_static();
        chk(n_overlap == 0, "R12", n_overlap, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule